// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Rotator

This block rotates a signed two-component vector by a phase angle, using one shift-and-add CORDIC iteration per pipeline stage. Feeding it the vector (A, 0) returns A·G·cos θ on one output and A·G·sin θ on the other in the same cycle. G is a fixed gain set by a parameter. A new input can be accepted every clock. A valid flag moves down the pipeline beside the data, so results can be collected without any handshake.

The angle is an unsigned binary fraction of a full turn. Angles in the second and third quadrants are folded at the entry stage: the vector is negated and half a turn is added to the angle. The remaining residual then lies within ±90°, which the iterations can reach.

The CORDIC iterations have a growth of about 1.647. The entry stage compensates part of it by scaling the input with shifts only. One setting uses a plain halving, which gives about 0.823 of full scale. The other uses the sum 1/2 + 1/16 + 1/32, which gives about 0.978 of full scale. In oscillator use, an internal phase accumulator can take the place of the angle input. In that mode the angle port is read as a frequency step.

Top module: `cordic_rotator`

## Requirements
- R1: For an input vector (x, y) of magnitude at most 2^(IN_W-1)-1 (or x = -2^(IN_W-1), y = 0), `cos_out` equals G·(x·cos θ − y·sin θ) and `sin_out` equals G·(x·sin θ + y·cos θ), each within 8 LSB.
- R2: Each sample accepted with `in_valid` high produces exactly one result with `out_valid` high, ITER+1 clock edges later. Back-to-back inputs give back-to-back results.
- R3: The angle is unsigned and ANG_W bits wide, where 2^ANG_W is one full turn. Code 0 is 0°, 2^(ANG_W-2) is 90°, 2^(ANG_W-1) is 180° and 3·2^(ANG_W-2) is 270°. Every quadrant is handled.
- R4: With GAIN_MODE = 0, G = 0.5·K, where K = Π over i from 0 to ITER−1 of sqrt(1+2^−2i), which is about 1.647. G is therefore about 0.823.
- R5: With GAIN_MODE = 1, G = 0.59375·K (about 0.978). The scaling is built from shifts and adds only.
- R6: While `acc_mode` is high, the angle used for a sample is the accumulator value. The accumulator adds `ang_in` (modulo 2^ANG_W) after each cycle in which `in_valid` and `acc_mode` are both high. It holds its value in every other cycle, whatever `ang_in` carries.
- R7: While `rst_n` is low, `out_valid` is low and the accumulator is cleared to 0. The first accumulated sample after reset therefore uses angle 0.
- R8: After the last iteration, the residual angle of a valid sample lies within ±(atan(2^−(ITER−1)) + ITER LSB).
- R9: After the entry stage, the angle has its two top bits equal, so it lies within [−90°, +90°). Input angles whose top two bits are 01 or 10 are rotated by 180° there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on the inputs is accepted this cycle |
| acc_mode | input | 1 | 1: the angle comes from the accumulator and `ang_in` is its step; 0: `ang_in` is the angle |
| x_in | input | IN_W | Signed X component of the input vector |
| y_in | input | IN_W | Signed Y component of the input vector |
| ang_in | input | ANG_W | Unsigned phase angle, or frequency step in accumulator mode |
| out_valid | output | 1 | Result outputs hold a valid sample |
| cos_out | output | OUT_W | Signed rotated X component |
| sin_out | output | OUT_W | Signed rotated Y component |

## Verification
The residual-angle bound assumes that the entry fold has placed the angle inside ±90°, and that the input vector stays within full-scale magnitude so that no stage wraps. The stimulus keeps every vector at or below magnitude 2^(IN_W-1), including the single most-negative X with zero Y. The valid-chain properties assume `in_valid` is held low during reset, and the bench drives it that way. The accumulator-hold property relies only on `in_valid` and `acc_mode` at the ports. The bench deliberately drives an unrelated `ang_in` value during the idle cycles so that this hold is exercised.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam real PI = 3.14159265358979323846;

  // arctangent of 2^-i in radians, by power series (i >= 1 converges fast)
  function automatic real atan_pow2(input int i);
    real x, x2, p, s, sgn;
    if (i == 0) return PI / 4.0;
    x = 1.0;
    for (int k = 0; k < i; k++) x = x / 2.0;
    x2 = x * x;
    p = x;
    s = 0.0;
    sgn = 1.0;
    for (int k = 0; k < 40; k++) begin
      s = s + sgn * p / real'(2 * k + 1);
      p = p * x2;
      sgn = -sgn;
    end
    return s;
  endfunction

  // angle step for iteration i, in units of 2^-ang_w turns
  function automatic longint atan_word(input int i, input int ang_w);
    return longint'(atan_pow2(i) / (2.0 * PI) * (2.0 ** ang_w));
  endfunction

endpackage

// File: rtl/cordic_phase_acc.sv
module cordic_phase_acc #(
  parameter int ANG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [ANG_W-1:0] freq,
  output logic [ANG_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (step) acc <= acc + freq;
  end
endmodule

// File: rtl/cordic_entry.sv
module cordic_entry #(
  parameter int IN_W      = 16,
  parameter int GUARD     = 6,
  parameter int ANG_W     = 24,
  parameter int GAIN_MODE = 0,
  localparam int W        = IN_W + GUARD + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   v_i,
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  input  logic [ANG_W-1:0]       ang_i,
  output logic                   v_o,
  output logic signed [W-1:0]    x_o,
  output logic signed [W-1:0]    y_o,
  output logic [ANG_W-1:0]       z_o
);
  // shift-only gain: x0.5, or x(1/2 + 1/16 + 1/32); result carries GUARD fraction bits
  function automatic logic signed [W-1:0] gain_scale(input logic signed [W-1:0] v);
    if (GAIN_MODE == 1)
      return (v <<< (GUARD - 1)) + (v <<< (GUARD - 4)) + (v <<< (GUARD - 5));
    else
      return v <<< (GUARD - 1);
  endfunction

  logic                fold;
  logic signed [W-1:0] x_ext, y_ext, x_fold, y_fold;
  logic [ANG_W-1:0]    z_fold;

  always_comb begin
    fold   = ang_i[ANG_W-1] ^ ang_i[ANG_W-2];
    x_ext  = W'(x_i);
    y_ext  = W'(y_i);
    x_fold = fold ? -x_ext : x_ext;
    y_fold = fold ? -y_ext : y_ext;
    z_fold = {ang_i[ANG_W-1] ^ fold, ang_i[ANG_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      x_o <= gain_scale(x_fold);
      y_o <= gain_scale(y_fold);
      z_o <= z_fold;
    end
  end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int               W     = 23,
  parameter int               ANG_W = 24,
  parameter int               SHIFT = 0,
  parameter logic [ANG_W-1:0] ATAN  = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic [ANG_W-1:0]    z_i,
  output logic                v_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic [ANG_W-1:0]    z_o
);
  logic                ccw;
  logic signed [W-1:0] x_sh, y_sh;

  always_comb begin
    ccw  = ~z_i[ANG_W-1];
    x_sh = x_i >>> SHIFT;
    y_sh = y_i >>> SHIFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      x_o <= ccw ? x_i - y_sh : x_i + y_sh;
      y_o <= ccw ? y_i + x_sh : y_i - x_sh;
      z_o <= ccw ? z_i - ATAN : z_i + ATAN;
    end
  end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int ANG_W     = 24,
  parameter int ITER      = 14,
  parameter int GUARD     = 6,
  parameter int GAIN_MODE = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    acc_mode,
  input  logic signed [IN_W-1:0]  x_in,
  input  logic signed [IN_W-1:0]  y_in,
  input  logic [ANG_W-1:0]        ang_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] sin_out
);
  localparam int W    = IN_W + GUARD + 1;
  localparam int DROP = GUARD + IN_W - OUT_W;

  function automatic logic signed [OUT_W-1:0] round_out(input logic signed [W-1:0] v);
    return OUT_W'((v + (W'(1) <<< (DROP - 1))) >>> DROP);
  endfunction

  logic                acc_step;
  logic [ANG_W-1:0]    acc_q;
  logic [ANG_W-1:0]    phase_sel;
  logic                vp [0:ITER];
  logic signed [W-1:0] xp [0:ITER];
  logic signed [W-1:0] yp [0:ITER];
  logic [ANG_W-1:0]    zp [0:ITER];

  // named taps for the checker
  logic [ITER:0]       vld_chain;
  logic [ANG_W-1:0]    z_head;
  logic [ANG_W-1:0]    z_tail;

  assign acc_step  = in_valid & acc_mode;
  assign phase_sel = acc_mode ? acc_q : ang_in;

  cordic_phase_acc #(.ANG_W(ANG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(acc_step), .freq(ang_in), .acc(acc_q)
  );

  cordic_entry #(
    .IN_W(IN_W), .GUARD(GUARD), .ANG_W(ANG_W), .GAIN_MODE(GAIN_MODE)
  ) u_entry (
    .clk(clk), .rst_n(rst_n), .v_i(in_valid), .x_i(x_in), .y_i(y_in), .ang_i(phase_sel),
    .v_o(vp[0]), .x_o(xp[0]), .y_o(yp[0]), .z_o(zp[0])
  );

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    cordic_stage #(
      .W(W), .ANG_W(ANG_W), .SHIFT(i),
      .ATAN(ANG_W'(cordic_pkg::atan_word(i, ANG_W)))
    ) u_stage (
      .clk(clk), .rst_n(rst_n),
      .v_i(vp[i]),   .x_i(xp[i]),   .y_i(yp[i]),   .z_i(zp[i]),
      .v_o(vp[i+1]), .x_o(xp[i+1]), .y_o(yp[i+1]), .z_o(zp[i+1])
    );
  end

  for (genvar i = 0; i <= ITER; i++) begin : g_tap
    assign vld_chain[i] = vp[i];
  end

  assign z_head    = zp[0];
  assign z_tail    = zp[ITER];
  assign out_valid = vp[ITER];
  assign cos_out   = round_out(xp[ITER]);
  assign sin_out   = round_out(yp[ITER]);
endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
  parameter int ANG_W = 24,
  parameter int ITER  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             acc_mode,
  input logic             out_valid,
  input logic [ITER:0]    vld_chain,
  input logic [ANG_W-1:0] z_head,
  input logic [ANG_W-1:0] z_tail,
  input logic [ANG_W-1:0] acc
);
  localparam longint BOUND = cordic_pkg::atan_word(ITER - 1, ANG_W) + ITER;

  // R2: valid enters the chain one edge after the port and moves one stage per edge
  assert_valid_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_chain[0] == ($past(in_valid) && $past(rst_n)));

  for (genvar i = 0; i < ITER; i++) begin : g_chain
    assert_valid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_chain[i+1] == $past(vld_chain[i]));
  end

  assert_valid_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_chain[ITER]);

  // R9: the folded angle lies within [-90, +90) degrees
  assert_fold_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_chain[0] |-> (z_head[ANG_W-1] == z_head[ANG_W-2]));

  // R8: residual angle after the last iteration is small
  assert_residual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(z_tail)) <= BOUND &&
                   longint'($signed(z_tail)) >= -BOUND));

  // R6: accumulator holds when no accumulated sample is taken
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && acc_mode) |=> $stable(acc));
endmodule

bind cordic_rotator cordic_rotator_chk #(.ANG_W(ANG_W), .ITER(ITER)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_mode(acc_mode),
  .out_valid(out_valid), .vld_chain(vld_chain), .z_head(z_head), .z_tail(z_tail),
  .acc(acc_q)
);

// File: tb/cordic_rotator_tb.sv
`timescale 1ns/1ps
module cordic_rotator_tb;
  localparam int IN_W  = 16;
  localparam int OUT_W = 16;
  localparam int ANG_W = 24;
  localparam int ITER  = 14;
  localparam int TOL   = 8;
  localparam int NV    = 12;
  localparam real PI   = 3.14159265358979323846;

  // x, y, angle (full turn = 2^24)
  localparam int VX [NV] = '{30000, 30000, 30000, 30000, 30000, 30000,
                             30000, 30000, 30000, -32768, 20000, 0};
  localparam int VY [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 20000, -25000};
  localparam int VA [NV] = '{'h000000, 'h155555, 'h200000, 'h3FFFFF, 'h400000, 'h600000,
                             'h800000, 'hC00000, 'hE00000, 'h2AAAAA, 'h100000, 'hA00000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic acc_mode = 1'b0;
  logic signed [IN_W-1:0] x_in = '0;
  logic signed [IN_W-1:0] y_in = '0;
  logic [ANG_W-1:0] ang_in = '0;
  logic ov0, ov1;
  logic signed [OUT_W-1:0] c0, s0, c1, s1;

  always #5 clk = ~clk;

  cordic_rotator #(.IN_W(IN_W), .OUT_W(OUT_W), .ANG_W(ANG_W), .ITER(ITER), .GAIN_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_mode(acc_mode),
    .x_in(x_in), .y_in(y_in), .ang_in(ang_in),
    .out_valid(ov0), .cos_out(c0), .sin_out(s0));

  cordic_rotator #(.IN_W(IN_W), .OUT_W(OUT_W), .ANG_W(ANG_W), .ITER(ITER), .GAIN_MODE(1)) u_dut_fine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_mode(acc_mode),
    .x_in(x_in), .y_in(y_in), .ang_in(ang_in),
    .out_valid(ov1), .cos_out(c1), .sin_out(s1));

  int n_total = 0;
  int n_fail = 0;
  int tx = 0;
  int rx = 0;
  bit done = 0;
  real kgain;
  int ec0 [0:127];
  int es0 [0:127];
  int ec1 [0:127];
  int es1 [0:127];
  string etag [0:127];

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    n_total++;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  // queue one sample; ang_used is the angle the requirements say is applied
  task automatic push(input int x, input int y, input int ang_used, input int ang_drive,
                      input string tag);
    real th, xr, yr;
    th = real'(ang_used) * 2.0 * PI / 16777216.0;
    xr = real'(x) * $cos(th) - real'(y) * $sin(th);
    yr = real'(x) * $sin(th) + real'(y) * $cos(th);
    ec0[tx] = rnd(0.5 * kgain * xr);
    es0[tx] = rnd(0.5 * kgain * yr);
    ec1[tx] = rnd(0.59375 * kgain * xr);
    es1[tx] = rnd(0.59375 * kgain * yr);
    etag[tx] = tag;
    tx++;
    x_in = IN_W'(x);
    y_in = IN_W'(y);
    ang_in = ANG_W'(ang_drive);
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rst_n && ov0) begin
      if (rx < tx) begin
        chk({etag[rx], " R1 R4 cos coarse gain"}, int'(c0), ec0[rx], TOL);
        chk({etag[rx], " R1 R4 sin coarse gain"}, int'(s0), es0[rx], TOL);
        chk({etag[rx], " R1 R5 cos fine gain"},   int'(c1), ec1[rx], TOL);
        chk({etag[rx], " R1 R5 sin fine gain"},   int'(s1), es1[rx], TOL);
      end else begin
        chk("R2 unexpected result", rx, tx - 1, 0);
      end
      rx++;
    end
    if (rst_n) chk("R2 both variants valid together", int'(ov1), int'(ov0), 0);
  end

  initial begin
    int acc_m;
    int cnt;
    kgain = 1.0;
    for (int i = 0; i < ITER; i++) kgain = kgain * $sqrt(1.0 + 1.0 / real'(64'd1 << (2 * i)));

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 out_valid in reset", int'(ov0), 0, 0);
    chk("R7 out_valid in reset fine", int'(ov1), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, back to back: R1 R3 R8 R9
    for (int k = 0; k < NV; k++) push(VX[k], VY[k], VA[k], VA[k], "R3 R8 R9 table");
    idle(ITER + 6);
    chk("R2 table results count", rx, tx, 0);

    // R6: accumulator mode with an idle gap carrying a junk step
    acc_mode = 1'b1;
    acc_m = 0;
    for (int k = 0; k < 3; k++) begin
      push(30000, 0, acc_m, 'h0A0000, "R6 accumulate");
      acc_m = (acc_m + 'h0A0000) & 'hFFFFFF;
    end
    ang_in = 24'h7FFFFF;
    idle(4);
    for (int k = 0; k < 2; k++) begin
      push(30000, 0, acc_m, 'h300000, "R6 hold across gap");
      acc_m = (acc_m + 'h300000) & 'hFFFFFF;
    end
    in_valid = 1'b0;
    acc_mode = 1'b0;
    idle(ITER + 6);

    // R7: reset mid-run clears the accumulator
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 out_valid during second reset", int'(ov0), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    acc_mode = 1'b1;
    push(30000, 0, 0, 'h123456, "R7 accumulator restarts at zero");
    in_valid = 1'b0;
    acc_mode = 1'b0;
    idle(ITER + 6);

    // R2: latency of an isolated sample
    push(12345, 0, 'h050000, 'h050000, "R2 isolated sample");
    cnt = 1;
    in_valid = 1'b0;
    while (!ov0 && cnt < 60) begin
      @(negedge clk);
      cnt++;
    end
    chk("R2 latency", cnt, ITER + 1, 0);
    idle(ITER + 6);
    chk("R2 every input produced one result", rx, tx, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule